// File: doc/BRIEF.md
# Interrupt Status and Masking Unit

This block gathers one-cycle event pulses from the rest of a network controller into a sticky status register. It combines them with a per-bit mask and a global enable to drive one registered, level-sensitive interrupt line. Software reaches three registers over a plain strobe-based register port: status, mask and control. Reading the status register returns the latched events and clears them, so each read reports the events that have arrived since the previous one.

One source, the PHY event, can be set to survive status reads. Its bit is cleared by a status read only when the auto-clear bit in the control register is set. When auto-clear is off, that bit stays latched across status reads. The global enable acts on the output line alone. Turning it off holds the interrupt inactive and leaves the status and mask contents as they were.

The register port carries control traffic only, so it has no valid/ready handshake. A read or write is a single-cycle strobe, and read data appears one cycle after its strobe.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset, the status register, the mask register and both control bits are 0, `irq_o` is 0 and `reg_rdata_o` is 0.
- R2: A pulse on `evt_i[k]` sets status bit k at the next clock edge, whatever the mask holds. The bit stays set until a status read clears it.
- R3: A read strobe at address 0 puts the status value held before the read on `reg_rdata_o` in the next cycle. At the same edge it clears every status bit other than the PHY bit.
- R4: An event that arrives in the same cycle as a clearing status read leaves its bit set after that read.
- R5: The mask register sits at address 1 and a write replaces it whole. A mask bit at 0 keeps its status bit out of the interrupt, but the status bit still latches.
- R6: `irq_o` is registered. It rises one cycle after (status AND mask) becomes nonzero while the enable is set, which is two cycles after the event pulse. It falls one cycle after that condition ends.
- R7: Bit 0 of the control register (address 2) is the global enable. At 0 it forces `irq_o` low from the next cycle on. Writing it changes neither the status nor the mask register.
- R8: Bit 1 of the control register is PHY auto-clear. The PHY source is status bit `PHY_IDX` (by default the top bit). A status read clears that bit only when auto-clear is 1.
- R9: Writes to address 0 or address 3 change no register, and a read of address 3 returns 0. Reads of the mask and control registers leave the status register unchanged.
- R10: `reg_rdata_o` is 0 in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | N | One-cycle event pulses, one per status bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 mask, 2 control, 3 unused |
| reg_wdata_i | input | N | Write data |
| reg_rdata_o | output | N | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Each result has a fixed due cycle:
- A status bit is due one edge after its event.
- Read data and the clearing of status bits are due one edge after the read strobe.
- The interrupt line is due one edge after any change in status, mask or enable, so it is due two edges after an event.

The bench drives every input just after a falling edge and samples at the next falling edge, one rising edge later. For the interrupt line it waits one more falling edge, so each comparison lands in the cycle the requirement names. A sweep of all event patterns against all mask values, with a small width, computes the expected interrupt level and the expected read values arithmetically. Directed sequences then cover the same-cycle read and event, the enable toggle, both auto-clear settings and the unused address.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_CTRL   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  localparam int CTRL_GEN_BIT = 0;
  localparam int CTRL_AC_BIT  = 1;

  typedef struct packed {
    logic phy_autoclr;
    logic global_en;
  } ctrl_t;

endpackage

// File: rtl/irq_status_cell.sv
module irq_status_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over clear so a coincident event is never lost
  always_ff @(posedge clk_i) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N       = 8,
  parameter int PHY_IDX = N - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         rd_clr_i,
  input  logic         phy_autoclr_i,
  output logic [N-1:0] status_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic clr;
    if (g == PHY_IDX) begin : g_phy
      assign clr = rd_clr_i & phy_autoclr_i;
    end else begin : g_plain
      assign clr = rd_clr_i;
    end
    irq_status_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_i[g]),
      .clr_i  (clr),
      .q_o    (status_o[g])
    );
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_mask_i,
  input  logic           wr_ctrl_i,
  input  logic [N-1:0]   wdata_i,
  output logic [N-1:0]   mask_o,
  output irq_pkg::ctrl_t ctrl_o
);
  import irq_pkg::*;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mask_o <= '0;
      ctrl_o <= '0;
    end else begin
      if (wr_mask_i) mask_o <= wdata_i;
      if (wr_ctrl_i) begin
        ctrl_o.global_en   <= wdata_i[CTRL_GEN_BIT];
        ctrl_o.phy_autoclr <= wdata_i[CTRL_AC_BIT];
      end
    end
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] mask_i,
  input  logic         global_en_i,
  output logic         irq_o
);
  logic hit;
  assign hit = |(status_i & mask_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= global_en_i & hit;
  end
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit #(
  parameter int N       = 8,
  parameter int PHY_IDX = N - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         reg_wr_i,
  input  logic         reg_rd_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [N-1:0] reg_wdata_i,
  output logic [N-1:0] reg_rdata_o,
  output logic         irq_o
);
  import irq_pkg::*;

  reg_sel_e     sel;
  logic         rd_status, wr_mask, wr_ctrl;
  logic [N-1:0] status_q, mask_q, rd_word;
  ctrl_t        ctrl_q;

  assign sel       = reg_sel_e'(reg_addr_i);
  assign rd_status = reg_rd_i && (sel == REG_STATUS);
  assign wr_mask   = reg_wr_i && (sel == REG_MASK);
  assign wr_ctrl   = reg_wr_i && (sel == REG_CTRL);

  irq_status_bank #(.N(N), .PHY_IDX(PHY_IDX)) u_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .evt_i         (evt_i),
    .rd_clr_i      (rd_status),
    .phy_autoclr_i (ctrl_q.phy_autoclr),
    .status_o      (status_q)
  );

  irq_cfg_regs #(.N(N)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_mask_i (wr_mask),
    .wr_ctrl_i (wr_ctrl),
    .wdata_i   (reg_wdata_i),
    .mask_o    (mask_q),
    .ctrl_o    (ctrl_q)
  );

  irq_out_stage #(.N(N)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .status_i    (status_q),
    .mask_i      (mask_q),
    .global_en_i (ctrl_q.global_en),
    .irq_o       (irq_o)
  );

  always_comb begin
    rd_word = '0;
    unique case (sel)
      REG_STATUS: rd_word = status_q;
      REG_MASK:   rd_word = mask_q;
      REG_CTRL: begin
        rd_word[CTRL_GEN_BIT] = ctrl_q.global_en;
        rd_word[CTRL_AC_BIT]  = ctrl_q.phy_autoclr;
      end
      default:    rd_word = '0;
    endcase
  end

  // captures the pre-clear status value on the read edge
  always_ff @(posedge clk_i) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_word;
    else               reg_rdata_o <= '0;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N       = 8,
  parameter int PHY_IDX = N - 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] evt_i,
  input logic         reg_rd_i,
  input logic         reg_wr_i,
  input logic [1:0]   reg_addr_i,
  input logic [N-1:0] status,
  input logic [N-1:0] mask,
  input logic         gen,
  input logic         ac,
  input logic         irq,
  input logic [N-1:0] rdata
);
  localparam logic [N-1:0] NONPHY = ~(N'(1) << PHY_IDX);

  logic rd0;
  assign rd0 = reg_rd_i && (reg_addr_i == 2'd0);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status & $past(evt_i)) == $past(evt_i)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd0 |=> ((status & $past(status)) == $past(status)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 |=> ((status & ~$past(evt_i) & NONPHY) == '0));

  p_rdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 |=> (rdata == $past(status)));

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gen && |(status & mask)) |=> irq);

  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & mask)) |=> !irq);

  p_gen_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |=> !irq);

  p_mask_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == 2'd1) |=> $stable(mask));

  p_phy_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && !ac && status[PHY_IDX]) |=> status[PHY_IDX]);

  p_phy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && ac && !evt_i[PHY_IDX]) |=> !status[PHY_IDX]);

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |=> (rdata == '0));
endmodule

bind irq_ctrl_unit irq_ctrl_chk #(.N(N), .PHY_IDX(PHY_IDX)) u_chk (
  .clk        (clk_i),
  .rst_n      (rst_ni),
  .evt_i      (evt_i),
  .reg_rd_i   (reg_rd_i),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .status     (status_q),
  .mask       (mask_q),
  .gen        (ctrl_q.global_en),
  .ac         (ctrl_q.phy_autoclr),
  .irq        (irq_o),
  .rdata      (reg_rdata_o)
);

// File: tb/tb_irq_ctrl_unit.sv
`timescale 1ns/1ps
module tb_irq_ctrl_unit;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] evt;
  logic         wr, rd;
  logic [1:0]   addr;
  logic [N-1:0] wdata, rdata;
  logic         irq;

  always #2.5 clk = ~clk;

  irq_ctrl_unit #(.N(N)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .evt_i       (evt),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [N-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [N-1:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    rst_n = 1'b0; evt = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 rdata after reset", 32'(rdata), 0);
    rreg(2'd0, d); chk("R1 status", 32'(d), 0);
    rreg(2'd1, d); chk("R1 mask", 32'(d), 0);
    rreg(2'd2, d); chk("R1 ctrl", 32'(d), 0);

    // sweep: enable and auto-clear on
    wreg(2'd2, 4'b0011);
    for (int ev = 0; ev < 16; ev++) begin
      for (int mk = 0; mk < 16; mk++) begin
        wreg(2'd1, N'(mk));
        pulse(N'(ev));
        @(negedge clk);
        chk("R6 R5 irq level", 32'(irq), 32'((ev & mk) != 0));
        rreg(2'd0, d);
        chk("R2 R5 status latched", 32'(d), 32'(ev));
        rreg(2'd0, d);
        chk("R3 status cleared", 32'(d), 0);
        chk("R6 irq falls", 32'(irq), 0);
      end
    end

    // R4: event coincident with a clearing read
    pulse(4'b0010);
    evt = 4'b0001; rd = 1'b1; addr = 2'd0;
    @(negedge clk);
    evt = '0; rd = 1'b0;
    chk("R3 pre-clear value", 32'(rdata), 32'h2);
    rreg(2'd0, d); chk("R4 coincident event kept", 32'(d), 32'h1);
    rreg(2'd0, d); chk("R4 then cleared", 32'(d), 0);

    // R7: global enable gates the pin only
    wreg(2'd1, 4'b0100);
    pulse(4'b0100);
    @(negedge clk);
    chk("R6 irq high", 32'(irq), 1);
    wreg(2'd2, 4'b0010);
    @(negedge clk);
    chk("R7 enable off forces low", 32'(irq), 0);
    rreg(2'd1, d); chk("R7 mask unchanged", 32'(d), 32'h4);
    rreg(2'd2, d); chk("R7 ctrl readback", 32'(d), 32'h2);
    wreg(2'd2, 4'b0011);
    @(negedge clk);
    chk("R7 status kept, irq back", 32'(irq), 1);
    rreg(2'd0, d); chk("R9 status kept over other reads", 32'(d), 32'h4);

    // R8: PHY bit without and with auto-clear
    wreg(2'd2, 4'b0001);
    wreg(2'd1, 4'b1000);
    pulse(4'b1001);
    rreg(2'd0, d); chk("R8 both latched", 32'(d), 32'h9);
    rreg(2'd0, d); chk("R8 phy survives read", 32'(d), 32'h8);
    chk("R8 irq from kept phy bit", 32'(irq), 1);
    wreg(2'd2, 4'b0011);
    rreg(2'd0, d); chk("R8 phy still set", 32'(d), 32'h8);
    rreg(2'd0, d); chk("R8 phy auto-cleared", 32'(d), 0);

    // R9: writes to status and address 3 ignored
    wreg(2'd0, 4'hF);
    rreg(2'd0, d); chk("R9 status write ignored", 32'(d), 0);
    wreg(2'd3, 4'hF);
    rreg(2'd1, d); chk("R9 mask untouched", 32'(d), 32'h8);
    rreg(2'd2, d); chk("R9 ctrl untouched", 32'(d), 32'h3);
    rreg(2'd3, d); chk("R9 addr 3 reads zero", 32'(d), 0);
    @(negedge clk);
    chk("R10 idle rdata zero", 32'(rdata), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule